// File: doc/BRIEF.md
# Dual-Panel Frame DMA Address Generator

This block produces the memory addresses a display pipeline uses to fetch frame data, one burst at a time. It holds one fetch channel per panel. In single-scan mode the upper channel walks the whole frame. In dual-scan mode the upper and lower channels each walk one half of it, from their own base addresses. Each channel keeps a current byte address and a count of the 32-bit words it still has to fetch. Both values reload from the host-programmed settings when a new-frame pulse is applied.

The display core raises a data request per panel. A small control stage turns these requests into bursts. It grants one channel at a time, alternates fairly between the panels in dual-scan mode, and clips each burst to the words that remain. The block then presents the burst start, address, length and channel to the bus master, and waits for a completion pulse before it issues the next burst. A per-channel end-of-frame flag reports when all the words of a channel have been fetched.

Top module: `frame_dma_addr_gen`

## Requirements
- R1: After reset no burst is issued, whatever the requests, until a new frame has been applied. Both end-of-frame flags read 1 after reset.
- R2: A configuration write takes effect only when all four byte enables are 1. A write with any other enable pattern leaves every setting unchanged. Select 0 holds the upper base and select 1 the lower base. Select 2 holds the geometry: width in bits [10:0], lines in bits [21:11], log2 of bits per pixel in bits [24:22] (codes above 4 count as 4). Select 3 holds the mode: bit 0 selects dual scan, and bits [7:4] hold the burst length minus one.
- R3: The frame size in words is width × lines × 2^bpp_code / 32, rounded down. In single-scan mode the upper channel fetches exactly that many words and the lower channel fetches none.
- R4: In dual-scan mode each channel fetches half the frame size, rounded down. The lower channel's first burst starts at the lower base.
- R5: Base, geometry and mode written during a frame affect only the frame started by the next applied new-frame pulse.
- R6: A channel's first burst starts at its base with bits [1:0] cleared. Each later burst of that channel starts 4 × (previous length) bytes further on.
- R7: Each burst length is the smaller of the programmed burst length and the channel's remaining word count, and is never zero.
- R8: A channel is eligible when its request is high and it has words left. When both are eligible, the channel not served last wins. After reset the upper channel wins the first tie. At most one burst is issued per cycle.
- R9: In single-scan mode the lower request is ignored and no burst carries the lower channel flag.
- R10: A burst is issued in the cycle after the edge that decided it. No new burst is issued until the completion pulse arrives. A new-frame pulse that arrives while a burst is outstanding is held, and is applied in the cycle after completion. No burst is issued in the cycle a reload is applied.
- R11: A channel's end-of-frame flag is 1 exactly when it has no words left and none of its bursts is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Setting selected for the write |
| cfg_be | input | 4 | Byte enables; only 4'hF writes |
| cfg_wdata | input | 32 | Write data |
| new_frame | input | 1 | New-frame pulse |
| dreq_upper | input | 1 | Core data request for the upper panel |
| dreq_lower | input | 1 | Core data request for the lower panel |
| rd_done | input | 1 | Completion pulse of the outstanding burst |
| rd_start | output | 1 | One-cycle burst issue strobe |
| rd_addr | output | 32 | Byte address of the burst |
| rd_len | output | 5 | Burst length in words |
| rd_lower | output | 1 | 1 when the burst belongs to the lower channel |
| eof_upper | output | 1 | Upper channel end of frame |
| eof_lower | output | 1 | Lower channel end of frame |

## Verification
Directed frames with small, known geometries check the word totals for single and dual scan. These tell a wrong size formula apart from a wrong halving. The same frames show that rewriting a base mid-frame takes effect only at the next frame, and that a partial write is ignored. A new frame held during an outstanding burst exposes early reloads. Random mixtures of requests, completion delays, stray new-frame pulses and writes with random enables stress the clipping of the last burst, the alternation between panels, and the end-of-frame timing. Each of these is compared against a cycle-level model that the bench builds from the requirements.

// File: rtl/fdag_pkg.sv
package fdag_pkg;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int HW   = 11;
    localparam int VW   = 11;
    localparam int BPPW = 3;
    localparam int CW   = HW + VW;
    localparam int PW   = HW + VW + 4;
    localparam int BLW  = 5;
    localparam int NCH  = 2;

    typedef enum logic {CH_UP = 1'b0, CH_LO = 1'b1} chan_e;

    typedef struct packed {
        logic [AW-1:0]    ubase;
        logic [AW-1:0]    lbase;
        logic [HW-1:0]    hpix;
        logic [VW-1:0]    vlin;
        logic [BPPW-1:0]  bpp_log;
        logic             dual;
        logic [BLW-2:0]   burst_m1;
    } cfg_t;

    typedef struct packed {
        logic             start;
        chan_e            ch;
        logic [AW-1:0]    addr;
        logic [BLW-1:0]   len;
    } burst_t;

    function automatic logic [CW-1:0] frame_words(input logic [HW-1:0] h,
                                                  input logic [VW-1:0] v,
                                                  input logic [BPPW-1:0] b);
        logic [PW-1:0] p;
        logic [2:0]    sh;
        sh = (b > 3'd4) ? 3'd4 : b;
        p  = PW'(h) * PW'(v);
        p  = p << sh;
        return CW'(p >> 5);
    endfunction

    function automatic logic [BLW-1:0] clip_len(input logic [BLW-1:0] burst,
                                                input logic [CW-1:0] left);
        return (CW'(burst) > left) ? BLW'(left) : burst;
    endfunction
endpackage

// File: rtl/fdag_cfg.sv
module fdag_cfg
    import fdag_pkg::*;
#(
    parameter int DWID = DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DWID/8-1:0] be,
    input  logic [DWID-1:0]   wdata,
    output cfg_t              regs
);
    localparam logic [DWID/8-1:0] FULL = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (we && be == FULL) begin
            case (sel)
                2'd0: regs.ubase <= AW'(wdata);
                2'd1: regs.lbase <= AW'(wdata);
                2'd2: begin
                    regs.hpix    <= wdata[HW-1:0];
                    regs.vlin    <= wdata[HW+VW-1:HW];
                    regs.bpp_log <= wdata[HW+VW+BPPW-1:HW+VW];
                end
                default: begin
                    regs.dual     <= wdata[0];
                    regs.burst_m1 <= wdata[4+BLW-2:4];
                end
            endcase
        end
    end

    // R2
    partial_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (we && be != FULL) |=> $stable(regs));
endmodule

// File: rtl/fdag_channel.sv
module fdag_channel #(
    parameter int AWID = 32,
    parameter int CWID = 22,
    parameter int LWID = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reload,
    input  logic [AWID-1:0] base_in,
    input  logic [CWID-1:0] size_in,
    input  logic            take,
    input  logic [LWID-1:0] take_len,
    input  logic            in_flight,
    output logic [AWID-1:0] addr,
    output logic [CWID-1:0] left,
    output logic            done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            left <= '0;
        end else if (reload) begin
            addr <= {base_in[AWID-1:2], 2'b00};
            left <= size_in;
        end else if (take) begin
            addr <= addr + AWID'({take_len, 2'b00});
            left <= left - CWID'(take_len);
        end
    end

    assign done = (left == '0) && !in_flight;

    // R3
    count_never_grows_chk: assert property (@(posedge clk) disable iff (rst)
        !reload |=> left <= $past(left));

    // R7
    burst_within_left_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> (take_len != '0 && CWID'(take_len) <= left));
endmodule

// File: rtl/fdag_arb.sv
module fdag_arb #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         dual,
    input  logic [N-1:0] want,
    output logic [N-1:0] gnt
);
    logic         last_lo;
    logic [N-1:0] eff;

    assign eff = {want[1] & dual, want[0]};

    always_comb begin
        gnt = '0;
        if (enable) begin
            if (&eff) gnt = last_lo ? 2'b01 : 2'b10;
            else      gnt = eff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       last_lo <= 1'b1;
        else if (|gnt) last_lo <= gnt[1];
    end

    // R8
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
endmodule

// File: rtl/frame_dma_addr_gen.sv
module frame_dma_addr_gen
    import fdag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [3:0]    cfg_be,
    input  logic [31:0]   cfg_wdata,
    input  logic          new_frame,
    input  logic          dreq_upper,
    input  logic          dreq_lower,
    input  logic          rd_done,
    output logic          rd_start,
    output logic [31:0]   rd_addr,
    output logic [4:0]    rd_len,
    output logic          rd_lower,
    output logic          eof_upper,
    output logic          eof_lower
);
    cfg_t            cfg;
    burst_t          out_q;
    logic            busy, nf_pend, act_dual;
    chan_e           busy_ch;
    logic [BLW-1:0]  act_burst;
    logic            apply, free;
    logic [NCH-1:0]  want, gnt, done;
    logic [AW-1:0]   ch_addr [NCH];
    logic [CW-1:0]   ch_left [NCH];
    logic [AW-1:0]   rl_base [NCH];
    logic [CW-1:0]   rl_size [NCH];
    logic [CW-1:0]   fw;
    chan_e           pick;
    logic [BLW-1:0]  issue_len;

    fdag_cfg #(.DWID(DW)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .be(cfg_be),
        .wdata(cfg_wdata), .regs(cfg)
    );

    assign apply = (new_frame || nf_pend) && !busy;
    assign free  = !busy && !apply;
    assign fw    = frame_words(cfg.hpix, cfg.vlin, cfg.bpp_log);

    assign rl_base[0] = cfg.ubase;
    assign rl_base[1] = cfg.lbase;
    assign rl_size[0] = cfg.dual ? (fw >> 1) : fw;
    assign rl_size[1] = cfg.dual ? (fw >> 1) : '0;

    assign pick      = gnt[1] ? CH_LO : CH_UP;
    assign issue_len = clip_len(act_burst, ch_left[pick]);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign want[i] = (i == 0 ? dreq_upper : dreq_lower) && (ch_left[i] != '0);
        fdag_channel #(.AWID(AW), .CWID(CW), .LWID(BLW)) u_ch (
            .clk(clk), .rst(rst), .reload(apply),
            .base_in(rl_base[i]), .size_in(rl_size[i]),
            .take(gnt[i]), .take_len(issue_len),
            .in_flight(busy && (busy_ch == chan_e'(i))),
            .addr(ch_addr[i]), .left(ch_left[i]), .done(done[i])
        );
    end

    fdag_arb #(.N(NCH)) u_arb (
        .clk(clk), .rst(rst), .enable(free), .dual(act_dual),
        .want(want), .gnt(gnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            busy_ch   <= CH_UP;
            nf_pend   <= 1'b0;
            act_dual  <= 1'b0;
            act_burst <= BLW'(1);
            out_q     <= '0;
        end else begin
            out_q.start <= |gnt;
            if (|gnt) begin
                out_q.ch   <= pick;
                out_q.addr <= ch_addr[pick];
                out_q.len  <= issue_len;
                busy       <= 1'b1;
                busy_ch    <= pick;
            end else if (rd_done) begin
                busy <= 1'b0;
            end
            if (apply) begin
                nf_pend   <= 1'b0;
                act_dual  <= cfg.dual;
                act_burst <= BLW'(cfg.burst_m1) + BLW'(1);
            end else if (new_frame) begin
                nf_pend <= 1'b1;
            end
        end
    end

    assign rd_start  = out_q.start;
    assign rd_addr   = out_q.addr;
    assign rd_len    = out_q.len;
    assign rd_lower  = (out_q.ch == CH_LO);
    assign eof_upper = done[0];
    assign eof_lower = done[1];

    // R10
    no_issue_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_done) |=> !rd_start);

    // R9
    single_scan_upper_only_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_start && !act_dual) |-> !rd_lower);
endmodule

// File: tb/frame_dma_addr_gen_test.sv
`timescale 1ns/1ps
module frame_dma_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 0, nf = 0, du = 0, dl = 0, rdone = 0;
    logic [1:0]  sel = 0;
    logic [3:0]  be = 0;
    logic [31:0] wd = 0;
    logic        rd_start, rd_lower, eof_upper, eof_lower;
    logic [31:0] rd_addr;
    logic [4:0]  rd_len;

    int vectors = 0, miscompares = 0;

    // bench model state
    logic [31:0] m_addr [2];
    int          m_cnt [2];
    bit          m_busy, m_bch, m_pend, m_dual, m_last;
    int          m_burst;
    logic [31:0] m_ub, m_lb, m_geo, m_ctl;

    // observation
    int          s_words [2];
    logic [31:0] f_addr [2];
    bit          f_seen [2];
    int          starts;

    always #2 clk = ~clk;

    frame_dma_addr_gen uut (
        .clk(clk), .rst(rst), .cfg_we(we), .cfg_sel(sel), .cfg_be(be),
        .cfg_wdata(wd), .new_frame(nf), .dreq_upper(du), .dreq_lower(dl),
        .rd_done(rdone), .rd_start(rd_start), .rd_addr(rd_addr),
        .rd_len(rd_len), .rd_lower(rd_lower), .eof_upper(eof_upper),
        .eof_lower(eof_lower)
    );

    function automatic int exp_words(int h, int v, int b);
        if (b > 4) b = 4;
        return (h * v * (1 << b)) / 32;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear_obs();
        for (int i = 0; i < 2; i++) begin
            s_words[i] = 0; f_seen[i] = 0; f_addr[i] = 0;
        end
        starts = 0;
    endtask

    task automatic tick();
        bit apply, eu, el, es, ech, eof_u, eof_l;
        int elen, fw;
        logic [31:0] eaddr;
        @(posedge clk);
        @(negedge clk);
        es = 0; ech = 0; elen = 0; eaddr = 0;
        apply = (nf || m_pend) && !m_busy;
        if (apply) begin
            fw        = exp_words(int'(m_geo[10:0]), int'(m_geo[21:11]), int'(m_geo[24:22]));
            m_dual    = m_ctl[0];
            m_burst   = int'(m_ctl[7:4]) + 1;
            m_addr[0] = {m_ub[31:2], 2'b00};
            m_addr[1] = {m_lb[31:2], 2'b00};
            m_cnt[0]  = m_dual ? fw / 2 : fw;
            m_cnt[1]  = m_dual ? fw / 2 : 0;
            m_pend    = 0;
        end else begin
            if (nf) m_pend = 1;
            if (m_busy) begin
                if (rdone) m_busy = 0;
            end else begin
                eu = du && m_cnt[0] != 0;
                el = m_dual && dl && m_cnt[1] != 0;
                if (eu || el) begin
                    es = 1;
                    if (eu && el) ech = !m_last;
                    else          ech = el;
                    elen  = (m_burst < m_cnt[ech]) ? m_burst : m_cnt[ech];
                    eaddr = m_addr[ech];
                    m_addr[ech] = m_addr[ech] + 32'(4 * elen);
                    m_cnt[ech]  = m_cnt[ech] - elen;
                    m_busy = 1; m_bch = ech; m_last = ech;
                end
            end
        end
        if (we && be == 4'hF) begin
            case (sel)
                2'd0: m_ub = wd;
                2'd1: m_lb = wd;
                2'd2: m_geo = wd;
                default: m_ctl = wd;
            endcase
        end
        // R10 issue timing, R8 channel choice, R6 address, R7 length
        chk(rd_start == es, "R10 start", 32'(rd_start), 32'(es));
        if (es && rd_start) begin
            chk(rd_lower == ech, "R8 channel", 32'(rd_lower), 32'(ech));
            chk(rd_addr == eaddr, "R6 address", rd_addr, eaddr);
            chk(int'(rd_len) == elen, "R7 length", 32'(rd_len), 32'(elen));
        end
        eof_u = (m_cnt[0] == 0) && !(m_busy && m_bch == 0);
        eof_l = (m_cnt[1] == 0) && !(m_busy && m_bch == 1);
        // R11
        chk(eof_upper == eof_u, "R11 eof_upper", 32'(eof_upper), 32'(eof_u));
        chk(eof_lower == eof_l, "R11 eof_lower", 32'(eof_lower), 32'(eof_l));
        if (rd_start) begin
            starts++;
            s_words[rd_lower] += int'(rd_len);
            if (!f_seen[rd_lower]) begin
                f_seen[rd_lower] = 1; f_addr[rd_lower] = rd_addr;
            end
        end
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d, logic [3:0] e);
        we = 1; sel = s; wd = d; be = e;
        tick();
        we = 0; be = 0;
    endtask

    task automatic pulse_nf();
        nf = 1; tick(); nf = 0;
    endtask

    task automatic run_frame(int maxc);
        du = 1; dl = 1;
        for (int c = 0; c < maxc; c++) begin
            if (m_cnt[0] == 0 && m_cnt[1] == 0 && !m_busy) break;
            rdone = m_busy;
            tick();
        end
        rdone = 0; du = 0; dl = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin m_addr[i] = 0; m_cnt[i] = 0; end
        m_busy = 0; m_bch = 0; m_pend = 0; m_dual = 0; m_last = 1; m_burst = 1;
        m_ub = 0; m_lb = 0; m_geo = 0; m_ctl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: requests before any frame issue nothing
        du = 1; dl = 1; clear_obs();
        repeat (4) tick();
        chk(starts == 0, "R1 no burst", 32'(starts), 0);
        chk(eof_upper && eof_lower, "R1 eof flags", {30'd0, eof_upper, eof_lower}, 32'd3);
        du = 0; dl = 0;

        // R2: partial write ignored
        wr(2'd0, 32'h0000_1000, 4'hF);
        wr(2'd0, 32'h0000_2000, 4'h3);
        wr(2'd2, {7'd0, 3'd0, 11'd1, 11'd32}, 4'hF);
        wr(2'd3, 32'h0000_0000, 4'hF);
        pulse_nf(); clear_obs();
        run_frame(50);
        chk(f_addr[0] == 32'h1000, "R2 partial write", f_addr[0], 32'h1000);

        // R3 + R5: single frame 16x4 at 8 bpp = 16 words, base rewritten mid-frame
        wr(2'd2, {7'd0, 3'd3, 11'd4, 11'd16}, 4'hF);
        wr(2'd3, 32'h0000_0030, 4'hF);
        pulse_nf(); clear_obs();
        du = 1; rdone = 0;
        for (int c = 0; c < 10 && starts == 0; c++) tick();
        wr(2'd0, 32'h0000_5000, 4'hF);
        run_frame(200);
        chk(s_words[0] == 16, "R3 single words", 32'(s_words[0]), 32'd16);
        chk(s_words[1] == 0, "R3 lower idle", 32'(s_words[1]), 0);
        chk(f_addr[0] == 32'h1000, "R5 old base kept", f_addr[0], 32'h1000);
        pulse_nf(); clear_obs();
        run_frame(200);
        chk(f_addr[0] == 32'h5000, "R5 new base", f_addr[0], 32'h5000);

        // R4: dual scan halves
        wr(2'd1, 32'h0000_8002, 4'hF);
        wr(2'd3, 32'h0000_0031, 4'hF);
        pulse_nf(); clear_obs();
        run_frame(200);
        chk(s_words[0] == 8, "R4 upper half", 32'(s_words[0]), 32'd8);
        chk(s_words[1] == 8, "R4 lower half", 32'(s_words[1]), 32'd8);
        chk(f_addr[1] == 32'h8000, "R4 lower base", f_addr[1], 32'h8000);

        // R9: single scan ignores lower requests
        wr(2'd3, 32'h0000_0030, 4'hF);
        pulse_nf(); clear_obs();
        dl = 1; du = 0;
        repeat (10) tick();
        chk(starts == 0, "R9 lower ignored", 32'(starts), 0);
        dl = 0;

        // R10: new frame held while a burst is outstanding
        du = 1; rdone = 0; clear_obs();
        for (int c = 0; c < 10 && starts == 0; c++) tick();
        nf = 1; tick(); nf = 0;
        clear_obs();
        repeat (5) tick();
        chk(starts == 0, "R10 held while busy", 32'(starts), 0);
        rdone = 1; tick(); rdone = 0;
        tick();
        chk(!rd_start, "R10 reload cycle idle", 32'(rd_start), 0);
        tick();
        chk(rd_start && rd_addr == 32'h5000, "R10 restart at base", rd_addr, 32'h5000);
        du = 0; rdone = 1; tick(); rdone = 0;

        // random phase
        for (int r = 0; r < 30; r++) begin
            wr(2'd0, $urandom, 4'hF);
            wr(2'd1, $urandom, 4'hF);
            wr(2'd2, {7'd0, 3'($urandom % 6), 11'(2 * (1 + $urandom % 10)),
                      11'(1 + $urandom % 40)}, 4'hF);
            wr(2'd3, {24'd0, 4'($urandom), 3'd0, 1'($urandom)}, 4'hF);
            pulse_nf();
            for (int c = 0; c < 600; c++) begin
                du    = ($urandom % 10) < 7;
                dl    = ($urandom % 10) < 7;
                rdone = $urandom % 2;
                nf    = ($urandom % 150) == 0;
                we    = ($urandom % 100) == 0;
                sel   = 2'($urandom);
                wd    = $urandom;
                be    = ($urandom % 3 == 0) ? 4'($urandom) : 4'hF;
                tick();
            end
            we = 0; nf = 0; du = 0; dl = 0;
            rdone = 1; tick(); rdone = 0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule